// File: doc/BRIEF.md
# Burst-Four Dual-Port DDR Memory

This block is a synchronous memory with a read port and a write port that work independently but share one address bus. Each accepted command moves a burst of four words. Double-data-rate transfer is modelled on one fast clock. An input phase flag, `pos_ph`, alternates every cycle and marks the slots that stand for the positive edge of the slow clock. Both selects are active low and are only looked at in those slots. In a slot where both selects are accepted, the read takes its burst address in the command slot and the write takes its burst address one slot later.

Each port is run by a small sequencer with five states: `PS_IDLE`, `PS_BEAT0`, `PS_BEAT1`, `PS_BEAT2` and `PS_BEAT3`. A start in `PS_IDLE` moves to `PS_BEAT0`. The beat states then step `PS_BEAT0`→`PS_BEAT1`→`PS_BEAT2`→`PS_BEAT3` unconditionally. `PS_BEAT3` goes to `PS_BEAT0` on a new start and to `PS_IDLE` otherwise. A start is only possible in `PS_IDLE` or `PS_BEAT3` during a positive slot.

Write beats are merged into the array one 9-bit lane at a time under active-low lane enables. Read beats pass through a fixed-latency pipeline. The pipeline also carries a valid flag, and that flag drives the output-enable.

Top module: `bq_burst_sram`

## Requirements
- R1: A select (`rd_sel_n`, `wr_sel_n`, active low) is accepted only in a cycle with `pos_ph`=1. A low select while `pos_ph`=0 starts nothing. The address, data and lane enables have no effect while the write port is not running a burst.
- R2: An accepted command runs four beats in the four cycles that follow it. A select held low in the positive slot of beat 1 is ignored. A select low in the positive slot of beat 3 starts the next burst with no gap.
- R3: The read burst address is the `addr` value in the command cycle. The write burst address is the `addr` value in the following cycle. The word address of beat k is {burst address, k[1:0]}, and beats run in the order 0,1,2,3.
- R4: For a write accepted in cycle c, beat k takes `wdata` and `wbe_n` from cycle c+1+k. Lane i covers bits 9i+8:9i. A lane is written when `wbe_n[i]`=0 and keeps its stored value when `wbe_n[i]`=1.
- R5: For a read accepted in cycle c, beat k is on `rdata` in cycle c+2·RD_LAT+k. `rvalid` and `q_oe` are 1 in exactly those cycles, so every run of `rvalid` is a multiple of four cycles long.
- R6: A read burst completes even when its select goes high right after the command. Whenever `rvalid` is 0, `q_oe` is 0 and `rdata` is all zeros (the disabled output).
- R7: A read and a write may both be accepted in the same positive slot. A read beat that targets a word written in the same cycle returns the word as it was before that write.
- R8: While reset is held and after it is released, `rvalid`=0, `q_oe`=0, `rdata`=0 and both ports are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per slow clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_ph | input | 1 | 1 in the positive-edge slot, alternates each cycle |
| rd_sel_n | input | 1 | Read select, active low |
| wr_sel_n | input | 1 | Write select, active low |
| addr | input | BURST_AW | Shared burst address bus |
| wdata | input | LANES*LANE_W | Write beat data |
| wbe_n | input | LANES | Active-low lane write enables, one per 9-bit lane |
| rdata | output | LANES*LANE_W | Read beat data, zero when disabled |
| q_oe | output | 1 | Read output enable |
| rvalid | output | 1 | Read data valid |

## Verification
The bench logs `rdata`, `rvalid` and `q_oe` at the falling edge of every numbered cycle. It checks read beat k of a command issued in cycle c at log entry c+2·RD_LAT+k, which is four cycles plus the beat index at the default latency. It also checks the entries just before and just after that window, which must show the output disabled. Write effects are due one cycle after each beat, so the bench checks them only through later reads. Expected words come from a shadow array that the bench updates lane by lane per R4. The bench snapshots that array when it issues a read, which is what gives the old-data result for a collision.

// File: rtl/bq_pkg.sv
package bq_pkg;
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_BEAT0,
        PS_BEAT1,
        PS_BEAT2,
        PS_BEAT3
    } port_state_e;

    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);
endpackage

// File: rtl/bq_port_seq.sv
module bq_port_seq
    import bq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pos_ph,
    input  logic              sel_n,
    output logic              start,
    output logic              active,
    output logic [BEAT_W-1:0] beat
);
    port_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start   = pos_ph && !sel_n &&
                  (state_q == PS_IDLE || state_q == PS_BEAT3);
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (start) state_d = PS_BEAT0;
            PS_BEAT0: state_d = PS_BEAT1;
            PS_BEAT1: state_d = PS_BEAT2;
            PS_BEAT2: state_d = PS_BEAT3;
            PS_BEAT3: state_d = start ? PS_BEAT0 : PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        active = 1'b1;
        beat   = '0;
        unique case (state_q)
            PS_IDLE:  active = 1'b0;
            PS_BEAT0: beat   = 2'd0;
            PS_BEAT1: beat   = 2'd1;
            PS_BEAT2: beat   = 2'd2;
            PS_BEAT3: beat   = 2'd3;
            default:  active = 1'b0;
        endcase
    end
endmodule

// File: rtl/bq_mem_array.sv
module bq_mem_array #(
    parameter int WORD_AW = 6,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [WORD_AW-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    input  logic [LANES-1:0]          wbe_n,
    input  logic [WORD_AW-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << WORD_AW;

    logic [DW-1:0] store [DEPTH];
    logic [DW-1:0] old_word;
    logic [DW-1:0] merged;

    assign old_word = store[waddr];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] =
            wbe_n[l] ? old_word[l*LANE_W +: LANE_W] : wdata[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= merged;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/bq_rd_pipe.sv
module bq_rd_pipe #(
    parameter int DW     = 36,
    parameter int STAGES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d
);
    logic [STAGES-1:0] v_q;
    logic [DW-1:0]     d_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
            for (int s = 0; s < STAGES; s++) d_q[s] <= '0;
        end else begin
            v_q[0] <= in_v;
            d_q[0] <= in_d;
            for (int s = 1; s < STAGES; s++) begin
                v_q[s] <= v_q[s-1];
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign out_v = v_q[STAGES-1];
    assign out_d = d_q[STAGES-1];
endmodule

// File: rtl/bq_burst_sram.sv
module bq_burst_sram
    import bq_pkg::*;
#(
    parameter int BURST_AW = 4,
    parameter int LANES    = 4,
    parameter int LANE_W   = 9,
    parameter int RD_LAT   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pos_ph,
    input  logic                     rd_sel_n,
    input  logic                     wr_sel_n,
    input  logic [BURST_AW-1:0]      addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES-1:0]         wbe_n,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     q_oe,
    output logic                     rvalid
);
    localparam int DW      = LANES * LANE_W;
    localparam int WORD_AW = BURST_AW + BEAT_W;
    localparam int PIPE    = 2 * RD_LAT - 1;

    logic              rd_start, rd_act;
    logic              wr_start, wr_act;
    logic [BEAT_W-1:0] rd_beat, wr_beat;
    logic [BURST_AW-1:0] raddr_q, waddr_q, wr_burst;
    logic [DW-1:0]     mem_q;
    logic              pipe_v;
    logic [DW-1:0]     pipe_d;

    bq_port_seq u_rd_seq (
        .clk(clk), .rst_n(rst_n), .pos_ph(pos_ph), .sel_n(rd_sel_n),
        .start(rd_start), .active(rd_act), .beat(rd_beat)
    );

    bq_port_seq u_wr_seq (
        .clk(clk), .rst_n(rst_n), .pos_ph(pos_ph), .sel_n(wr_sel_n),
        .start(wr_start), .active(wr_act), .beat(wr_beat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr_q <= '0;
            waddr_q <= '0;
        end else begin
            if (rd_start) raddr_q <= addr;
            if (wr_act && wr_beat == '0) waddr_q <= addr;
        end
    end

    assign wr_burst = (wr_beat == '0) ? addr : waddr_q;

    bq_mem_array #(.WORD_AW(WORD_AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(wr_act), .waddr({wr_burst, wr_beat}),
        .wdata(wdata), .wbe_n(wbe_n),
        .raddr({raddr_q, rd_beat}), .rdata(mem_q)
    );

    bq_rd_pipe #(.DW(DW), .STAGES(PIPE)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_v(rd_act), .in_d(rd_act ? mem_q : '0),
        .out_v(pipe_v), .out_d(pipe_d)
    );

    assign rvalid = pipe_v;
    assign q_oe   = pipe_v;
    assign rdata  = pipe_d;
endmodule

// File: rtl/bq_burst_sram_chk.sv
module bq_burst_sram_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pos_ph,
    input logic          rd_sel_n,
    input logic          wr_sel_n,
    input logic          rd_start,
    input logic          wr_start,
    input logic          rd_act,
    input logic          wr_act,
    input logic [1:0]    rd_beat,
    input logic [1:0]    wr_beat,
    input logic          rvalid,
    input logic          q_oe,
    input logic [DW-1:0] rdata
);
    logic [7:0] vcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)      vcnt <= '0;
        else if (rvalid) vcnt <= vcnt + 8'd1;
        else             vcnt <= '0;
    end

    a_r1_rd_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_act) |-> ($past(pos_ph) && !$past(rd_sel_n)));
    a_r1_wr_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_act) |-> ($past(pos_ph) && !$past(wr_sel_n)));
    a_r2_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_beat != 2'd3) |=> (rd_act && rd_beat == $past(rd_beat) + 2'd1));
    a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && wr_beat != 2'd3) |=> (wr_act && wr_beat == $past(wr_beat) + 2'd1));
    a_r2_rd_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (rd_act && rd_beat == 2'd0));
    a_r2_wr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (wr_act && wr_beat == 2'd0));
    a_r5_valid_runs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rvalid) |-> (vcnt[1:0] == 2'd0));
    a_r6_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0 && !q_oe));
endmodule

bind bq_burst_sram bq_burst_sram_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pos_ph(pos_ph),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .rd_start(rd_start), .wr_start(wr_start),
    .rd_act(rd_act), .wr_act(wr_act),
    .rd_beat(rd_beat), .wr_beat(wr_beat),
    .rvalid(rvalid), .q_oe(q_oe), .rdata(rdata)
);

// File: tb/sim_bq_burst_sram.sv
module sim_bq_burst_sram;
    localparam int AW = 4, LANES = 4, DW = 36, LAT = 2, LOGN = 4096, DEPTH = 64;

    logic clk = 1'b0, rst_n = 1'b0, pos_ph = 1'b0;
    logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [LANES-1:0] wbe_n = '1;
    logic [DW-1:0] rdata;
    logic q_oe, rvalid;

    bq_burst_sram #(.BURST_AW(AW), .LANES(LANES), .LANE_W(9), .RD_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .pos_ph(pos_ph), .rd_sel_n(rd_sel_n),
        .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
        .rdata(rdata), .q_oe(q_oe), .rvalid(rvalid)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] log_q [LOGN];
    logic          log_v [LOGN];
    logic          log_oe [LOGN];
    always @(negedge clk) begin
        if (cyc < LOGN) begin
            log_q[cyc]  <= rdata;
            log_v[cyc]  <= rvalid;
            log_oe[cyc] <= q_oe;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [DEPTH];
    int            pend_c0 [8];
    string         pend_req [8];
    logic [DW-1:0] pend_e [8][4];
    int            npend = 0;

    // Each entry: burst address, lane enables (active low), data seed.
    localparam logic [43:0] VEC [6] = '{
        {4'd1, 4'b0000, 36'h1_2345_6789},
        {4'd2, 4'b0000, 36'hA_BCDE_F012},
        {4'd3, 4'b0000, 36'h5_5AA5_33CC},
        {4'd1, 4'b0101, 36'hF_0F0F_0F0F},
        {4'd2, 4'b1110, 36'h0_7777_8888},
        {4'd3, 4'b1111, 36'hE_DCBA_9876}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word(input logic [DW-1:0] seed, input int k);
        return seed ^ (36'h0_2468_ACE1 * (k + 1));
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                            input logic [LANES-1:0] be);
        logic [DW-1:0] r = old;
        for (int i = 0; i < LANES; i++) if (!be[i]) r[i*9 +: 9] = d[i*9 +: 9];
        return r;
    endfunction

    task automatic drive(input logic rs, input logic ws, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [LANES-1:0] be);
        @(posedge clk); #1;
        pos_ph = ~cyc[0];
        rd_sel_n = rs; wr_sel_n = ws; addr = a; wdata = d; wbe_n = be;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, '0, '0, '1);
    endtask

    task automatic sync_pos();
        if (((cyc + 1) % 2) != 0) idle(1);
    endtask

    task automatic snap(input int c0, input logic [AW-1:0] a, input string req);
        pend_c0[npend] = c0;
        pend_req[npend] = req;
        for (int k = 0; k < 4; k++) pend_e[npend][k] = model[{a, 2'(k)}];
        npend++;
    endtask

    task automatic check_pend();
        for (int p = 0; p < npend; p++) begin
            for (int k = 0; k < 4; k++) begin
                int idx = pend_c0[p] + 2 * LAT + k;
                chk(log_v[idx] === 1'b1 && log_oe[idx] === 1'b1, "R5",
                    "valid and enable on beat", {34'd0, log_v[idx], log_oe[idx]}, 36'd3);
                chk(log_q[idx] === pend_e[p][k], pend_req[p], "beat data",
                    log_q[idx], pend_e[p][k]);
            end
        end
        npend = 0;
    endtask

    task automatic check_edges(input int c0, input int beats);
        chk(log_v[c0 + 2*LAT - 1] === 1'b0 && log_q[c0 + 2*LAT - 1] === '0, "R5",
            "idle before window", log_q[c0 + 2*LAT - 1], '0);
        chk(log_v[c0 + 2*LAT + beats] === 1'b0 && log_oe[c0 + 2*LAT + beats] === 1'b0, "R6",
            "disabled after window", {35'd0, log_v[c0 + 2*LAT + beats]}, '0);
    endtask

    task automatic wr_burst(input logic [AW-1:0] a, input logic [DW-1:0] seed,
                            input logic [LANES-1:0] be);
        sync_pos();
        drive(1'b1, 1'b0, ~a, '0, '1);
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 1'b1, (k == 0) ? a : ~a, word(seed, k), be);
            model[{a, 2'(k)}] = merge(model[{a, 2'(k)}], word(seed, k), be);
        end
    endtask

    task automatic rd_one(input logic [AW-1:0] a, input string req);
        int c0;
        sync_pos();
        drive(1'b0, 1'b1, a, '0, '1);
        c0 = cyc;
        snap(c0, a, req);
        idle(2 * LAT + 6);
        check_edges(c0, 4);
        check_pend();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        idle(3);
        @(negedge clk);
        chk(rvalid === 1'b0 && q_oe === 1'b0 && rdata === '0, "R8", "outputs in reset",
            rdata, '0);
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk(rvalid === 1'b0 && q_oe === 1'b0 && rdata === '0, "R8", "outputs after reset",
            rdata, '0);

        // Vector table: write a burst under lane enables, read it back (R3, R4, R5).
        for (int i = 0; i < 6; i++) begin
            wr_burst(VEC[i][43:40], VEC[i][35:0], VEC[i][39:36]);
            rd_one(VEC[i][43:40], "R4");
        end

        // R1: selects low only in a negative slot start nothing; bus activity ignored.
        begin
            int c0;
            sync_pos();
            drive(1'b1, 1'b1, 4'd1, '1, '0);
            c0 = cyc;
            drive(1'b0, 1'b0, 4'd1, '1, '0);
            drive(1'b1, 1'b1, 4'd1, '1, '0);
            drive(1'b1, 1'b1, 4'd1, '1, '0);
            idle(10);
            begin
                int seen = 0;
                for (int c = c0; c < c0 + 13; c++) if (log_v[c] !== 1'b0) seen++;
                chk(seen == 0, "R1", "no read from negative-slot select", 36'(seen), '0);
            end
            rd_one(4'd1, "R1");
        end

        // R2: select held low across two bursts, middle positive slot ignored; R6 completion.
        begin
            int c0;
            sync_pos();
            drive(1'b0, 1'b1, 4'd2, '0, '1);
            c0 = cyc;
            snap(c0, 4'd2, "R2");
            drive(1'b0, 1'b1, 4'd5, '0, '1);
            drive(1'b0, 1'b1, 4'd5, '0, '1);
            drive(1'b0, 1'b1, 4'd5, '0, '1);
            drive(1'b0, 1'b1, 4'd3, '0, '1);
            snap(c0 + 4, 4'd3, "R2");
            idle(2 * LAT + 10);
            check_edges(c0, 8);
            check_pend();
        end

        // R7/R3: same-slot read of 1 and write to 3 (address taken in the next slot).
        begin
            int c0;
            sync_pos();
            drive(1'b0, 1'b0, 4'd1, '0, '1);
            c0 = cyc;
            snap(c0, 4'd1, "R7");
            for (int k = 0; k < 4; k++) begin
                drive(1'b1, 1'b1, (k == 0) ? 4'd3 : 4'd1, word(36'h3_1415_9265, k), '0);
                model[{4'd3, 2'(k)}] = word(36'h3_1415_9265, k);
            end
            idle(2 * LAT + 4);
            check_pend();
            rd_one(4'd3, "R3");
            rd_one(4'd1, "R3");
        end

        // R7: same-slot read and write of the same burst return the old words.
        begin
            int c0;
            sync_pos();
            drive(1'b0, 1'b0, 4'd2, '0, '1);
            c0 = cyc;
            snap(c0, 4'd2, "R7");
            for (int k = 0; k < 4; k++) begin
                drive(1'b1, 1'b1, 4'd2, word(36'h9_8765_4321, k), 4'b0011);
                model[{4'd2, 2'(k)}] = merge(model[{4'd2, 2'(k)}], word(36'h9_8765_4321, k), 4'b0011);
            end
            idle(2 * LAT + 4);
            check_pend();
            rd_one(4'd2, "R7");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule